// File: doc/BRIEF.md
# Masked Half-Word GPIO Output Register

This block keeps the two output-side control words of a general-purpose I/O port. One word holds the value driven on each pad. The other word holds the per-pad drive enable. A plain full-width write replaces either word at once. Each word also has two masked-access addresses, one for its low half and one for its high half. A write to a masked address carries a per-bit select mask in its upper half and new bit values in its lower half. Software can therefore set or clear any chosen bits of one half-word in a single write, with no read-modify-write sequence and no race against other agents that share the port.

The write interface is deliberately simple: one address, one data word and one strobe per cycle. An update lands on the clock edge that samples the strobe. The read data is combinational from the same address, so any register can be read back. The pad vectors are driven directly from the two state registers.

Address map (`addr`): 0 value full word, 1 value low-half masked, 2 value high-half masked, 3 enable full word, 4 enable low-half masked, 5 enable high-half masked. Addresses 6 and 7 are unused. There is no state machine: the only states are the two held words. The only transitions are the three write kinds per word, plus reset.

Top module: `gpo_masked_out`

## Requirements
- R1: After reset, `pad_out` and `pad_oe` are both all zeros.
- R2: A strobed write to address 0 (value) or 3 (enable) replaces all 32 bits of that word at the next clock edge.
- R3: A strobed write to address 1 or 4 updates the low half (bits 15:0) of its word. Each bit whose mask bit `wdata[16+i]` is 1 takes `wdata[i]`; every other bit, and the whole high half, keeps its value.
- R4: A strobed write to address 2 or 5 updates the high half (bits 31:16) of its word. Each bit `16+i` whose mask bit `wdata[16+i]` is 1 takes `wdata[i]`; every other bit, and the whole low half, keeps its value.
- R5: A masked write whose mask field `wdata[31:16]` is all zeros leaves the word unchanged.
- R6: Writes to addresses 0–2 never change the enable word, and writes to addresses 3–5 never change the value word.
- R7: Reading address 0 or 3 returns the full word. Reading a masked address returns zero in bits 31:16 and, in bits 15:0, the half that address acts on.
- R8: With `wr_en` low, or with `addr` 6 or 7, neither word changes; reads of 6 and 7 return zero.
- R9: `pad_out` and `pad_oe` equal the held words with no added delay, so a write is visible on the pads one edge after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register select for write and read |
| wdata | input | 32 | Write data (masked: mask in 31:16, values in 15:0) |
| rdata | output | 32 | Read-back data for `addr` |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
A wrong internal state cannot hide, because both held words drive the pads directly. A bad merge, a write steered to the wrong half or to the wrong word, or a spurious update therefore shows on `pad_out` or `pad_oe` one edge after the offending strobe. The bench compares both vectors after every write against a word-level model built from the requirements. It reads each address back so that faults in the read path show in the same cycle the address is applied.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    typedef enum logic [2:0] {
        ADR_VAL_FULL = 3'd0,
        ADR_VAL_LO   = 3'd1,
        ADR_VAL_HI   = 3'd2,
        ADR_EN_FULL  = 3'd3,
        ADR_EN_LO    = 3'd4,
        ADR_EN_HI    = 3'd5,
        ADR_RSVD6    = 3'd6,
        ADR_RSVD7    = 3'd7
    } gpo_addr_e;

    localparam int unsigned NUM_TARGETS = 2;
    localparam int unsigned TGT_VAL = 0;
    localparam int unsigned TGT_EN  = 1;

    typedef struct packed {
        logic full;
        logic lo;
        logic hi;
    } gpo_wsel_t;

endpackage

// File: rtl/gpo_wr_decode.sv
module gpo_wr_decode
    import gpo_pkg::*;
(
    input  logic      wr_en,
    input  logic [2:0] addr,
    output gpo_wsel_t sel [NUM_TARGETS]
);

    gpo_addr_e adr;
    assign adr = gpo_addr_e'(addr);

    always_comb begin
        for (int t = 0; t < NUM_TARGETS; t++) begin
            sel[t] = '0;
        end
        if (wr_en) begin
            unique case (adr)
                ADR_VAL_FULL: sel[TGT_VAL].full = 1'b1;
                ADR_VAL_LO:   sel[TGT_VAL].lo   = 1'b1;
                ADR_VAL_HI:   sel[TGT_VAL].hi   = 1'b1;
                ADR_EN_FULL:  sel[TGT_EN].full  = 1'b1;
                ADR_EN_LO:    sel[TGT_EN].lo    = 1'b1;
                ADR_EN_HI:    sel[TGT_EN].hi    = 1'b1;
                ADR_RSVD6, ADR_RSVD7: ;
            endcase
        end
    end

endmodule

// File: rtl/gpo_target_reg.sv
module gpo_target_reg
    import gpo_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gpo_wsel_t        sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    localparam int unsigned HALF = WIDTH / 2;

    logic [HALF-1:0] mask_f;
    logic [HALF-1:0] vals_f;
    assign mask_f = wdata[WIDTH-1:HALF];
    assign vals_f = wdata[HALF-1:0];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic            hit;
        logic [HALF-1:0] cur;
        logic [HALF-1:0] merged;

        assign hit    = (h == 0) ? sel.lo : sel.hi;
        assign cur    = q[h*HALF +: HALF];
        assign merged = (cur & ~mask_f) | (vals_f & mask_f);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[h*HALF +: HALF] <= '0;
            end else if (sel.full) begin
                q[h*HALF +: HALF] <= wdata[h*HALF +: HALF];
            end else if (hit) begin
                q[h*HALF +: HALF] <= merged;
            end
        end
    end

endmodule

// File: rtl/gpo_rd_mux.sv
module gpo_rd_mux
    import gpo_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [2:0]       addr,
    input  logic [WIDTH-1:0] q_val,
    input  logic [WIDTH-1:0] q_en,
    output logic [WIDTH-1:0] rdata
);

    localparam int unsigned HALF = WIDTH / 2;

    always_comb begin
        unique case (gpo_addr_e'(addr))
            ADR_VAL_FULL: rdata = q_val;
            ADR_VAL_LO:   rdata = {{HALF{1'b0}}, q_val[HALF-1:0]};
            ADR_VAL_HI:   rdata = {{HALF{1'b0}}, q_val[WIDTH-1:HALF]};
            ADR_EN_FULL:  rdata = q_en;
            ADR_EN_LO:    rdata = {{HALF{1'b0}}, q_en[HALF-1:0]};
            ADR_EN_HI:    rdata = {{HALF{1'b0}}, q_en[WIDTH-1:HALF]};
            ADR_RSVD6, ADR_RSVD7: rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpo_masked_out.sv
module gpo_masked_out
    import gpo_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    gpo_wsel_t        sel [NUM_TARGETS];
    logic [WIDTH-1:0] q   [NUM_TARGETS];

    gpo_wr_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .sel   (sel)
    );

    for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tgt
        gpo_target_reg #(.WIDTH(WIDTH)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel[t]),
            .wdata (wdata),
            .q     (q[t])
        );
    end

    gpo_rd_mux #(.WIDTH(WIDTH)) u_rd (
        .addr  (addr),
        .q_val (q[TGT_VAL]),
        .q_en  (q[TGT_EN]),
        .rdata (rdata)
    );

    assign pad_out = q[TGT_VAL];
    assign pad_oe  = q[TGT_EN];

endmodule

// File: rtl/gpo_masked_out_chk.sv
module gpo_masked_out_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [WIDTH-1:0] wdata,
    input logic [WIDTH-1:0] rdata,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe
);

    localparam int unsigned HALF = WIDTH / 2;

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr > 3'd5) |=> ($stable(pad_out) && $stable(pad_oe)));

    assert_val_write_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr <= 3'd2) |=> $stable(pad_oe));

    assert_en_write_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= 3'd3 && addr <= 3'd5) |=> $stable(pad_out));

    assert_lo_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1) |=> pad_out[WIDTH-1:HALF] == $past(pad_out[WIDTH-1:HALF]));

    assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd5) |=> pad_oe[HALF-1:0] == $past(pad_oe[HALF-1:0]));

    assert_zero_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 3'd1 || addr == 3'd2) && wdata[WIDTH-1:HALF] == '0)
        |=> $stable(pad_out));

    assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=> pad_out == $past(wdata));

    assert_read_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd3) |-> rdata == pad_oe);

    assert_read_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd1 || addr == 3'd2 || addr == 3'd4 || addr == 3'd5)
        |-> rdata[WIDTH-1:HALF] == '0);

endmodule

bind gpo_masked_out gpo_masked_out_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
);

// File: tb/gpo_masked_out_tb.sv
module gpo_masked_out_tb_top;

    localparam int  W        = 32;
    localparam time CLK_PER  = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata, pad_out, pad_oe;

    int vectors = 0;
    int misses  = 0;
    logic [W-1:0] m_val = '0;
    logic [W-1:0] m_en  = '0;

    always #(CLK_PER/2) clk = ~clk;

    gpo_masked_out #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] merge(input logic [W-1:0] cur, input logic [W-1:0] d, input bit hi);
        logic [W-1:0] m = '0, v = '0;
        if (hi) begin m = {d[31:16], 16'h0}; v = {d[15:0], 16'h0}; end
        else    begin m = {16'h0, d[31:16]}; v = {16'h0, d[15:0]}; end
        return (cur & ~m) | (v & m);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input bit strobe = 1);
        @(negedge clk);
        wr_en = strobe; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (strobe) begin
            case (a)
                3'd0: m_val = d;
                3'd1: m_val = merge(m_val, d, 0);
                3'd2: m_val = merge(m_val, d, 1);
                3'd3: m_en  = d;
                3'd4: m_en  = merge(m_en, d, 0);
                3'd5: m_en  = merge(m_en, d, 1);
                default: ;
            endcase
        end
    endtask

    task automatic chk_pads(input string req);
        chk({req, " pad_out"}, pad_out, m_val);
        chk({req, " pad_oe"},  pad_oe,  m_en);
    endtask

    task automatic t_reset;
        chk_pads("R1");
    endtask

    task automatic t_full;
        wr(3'd0, 32'hDEAD_BEEF); chk_pads("R2 R9");
        wr(3'd3, 32'h0F0F_1234); chk_pads("R2");
        wr(3'd0, 32'h1357_9BDF); chk_pads("R2");
    endtask

    task automatic t_lo;
        wr(3'd0, 32'hAAAA_5555);
        wr(3'd1, 32'h00FF_1234); chk_pads("R3");
        chk("R3 value", pad_out, 32'hAAAA_5534);
        wr(3'd4, 32'hF000_FFFF); chk_pads("R3 enable");
        wr(3'd1, 32'hFFFF_0000); chk_pads("R3 clear all");
    endtask

    task automatic t_hi;
        wr(3'd0, 32'h0000_0000);
        wr(3'd2, 32'h8001_FFFF); chk_pads("R4");
        chk("R4 value", pad_out, 32'h8001_0000);
        wr(3'd5, 32'h00F0_00A0); chk_pads("R4 enable");
    endtask

    task automatic t_zero_mask;
        wr(3'd1, 32'h0000_FFFF); chk_pads("R5 lo");
        wr(3'd5, 32'h0000_FFFF); chk_pads("R5 hi");
    endtask

    task automatic t_isolation;
        logic [W-1:0] en0 = m_en, val0;
        wr(3'd0, 32'h7777_7777); chk("R6 enable kept", pad_oe, en0);
        wr(3'd2, 32'hFFFF_0000); chk("R6 enable kept", pad_oe, en0);
        val0 = m_val;
        wr(3'd3, 32'h1111_2222); chk("R6 value kept", pad_out, val0);
        wr(3'd4, 32'hFFFF_FFFF); chk("R6 value kept", pad_out, val0);
    endtask

    task automatic t_ignored;
        wr(3'd0, 32'h5A5A_5A5A, 0); chk_pads("R8 no strobe");
        wr(3'd6, 32'hFFFF_FFFF);    chk_pads("R8 addr6");
        wr(3'd7, 32'hFFFF_FFFF);    chk_pads("R8 addr7");
    endtask

    task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string req);
        @(negedge clk); addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic t_read;
        wr(3'd0, 32'hCAFE_F00D);
        wr(3'd3, 32'h1234_5678);
        rd(3'd0, m_val, "R7 val full");
        rd(3'd1, {16'h0, m_val[15:0]},  "R7 val lo");
        rd(3'd2, {16'h0, m_val[31:16]}, "R7 val hi");
        rd(3'd3, m_en, "R7 en full");
        rd(3'd4, {16'h0, m_en[15:0]},  "R7 en lo");
        rd(3'd5, {16'h0, m_en[31:16]}, "R7 en hi");
        rd(3'd6, '0, "R8 read6");
        rd(3'd7, '0, "R8 read7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_lo();
        t_hi();
        t_zero_mask();
        t_isolation();
        t_ignored();
        t_read();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++; misses++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule